// File: doc/BRIEF.md
# Multi-lane PRBS self-test checker

This block sits on the receive side of a four-lane serial link, after deserialization. In normal operation it forwards each lane's recovered 8-bit word onto a 32-bit parallel output bus. When self-test is requested, it waits until lane 0 has carried an unbroken run of clock-pattern symbols. It then stops forwarding data and checks every lane against its own PRBS-7 generator (x^7 + x^6 + 1). Each generator is seeded from the first word that the lane delivers once test mode has been recognised.

Each lane keeps three pieces of state: a count of compared symbols, a saturating 7-bit mismatch count, and a pass flag. The pass flag rises once a configurable number of symbols has been checked (44,000,000 by default) and then stays high. While in test mode, the output bus carries one 8-bit status field per lane in place of data. All checking pauses while the receive PLL is unlocked. Dropping the test request returns the bus to data and wipes every lane's state.

Top module: `mlp_bist_checker`

## Requirements
- R1: When test mode is not active, output bits [8k+7:8k] show the word that lane k delivered with its valid strobe on the most recent accepted cycle, one clock after that cycle. After reset these bits are 0.
- R2: Test mode becomes active one clock after the CLK_RUN-th consecutive valid lane-0 word equal to 8'hF0. Only words received while test_en and pll_lock are both high count. A valid lane-0 word of any other value restarts the run.
- R3: While test mode is active, bit 8k is lane k's pass flag and bits [8k+7:8k+1] are lane k's mismatch count.
- R4: The first word that lane k accepts in test mode seeds that lane's 7-bit state from its bits [6:0], and is not compared. Each later accepted word is compared with 8 bits produced MSB first. Each produced bit is s[6] XOR s[5] and is shifted into s[0]. After each word the state equals bits [6:0] of the expected word, whether or not the received word matched.
- R5: Each accepted word that differs from the expected word raises that lane's mismatch count by one. The count stops at 127 and does not wrap.
- R6: A lane's pass flag goes high one clock after that lane's PASS_SYMS-th compared word. Mismatches have no effect on when it rises.
- R7: Once high, a pass flag stays high while test mode remains active, even when later words mismatch.
- R8: Mismatches on one lane leave every other lane's count and flag unchanged.
- R9: While pll_lock is low, valid words have no effect on any count, flag, seed or clock-pattern run.
- R10: Lowering test_en ends test mode on the next clock and clears all lane state. A later entry requires a fresh clock-pattern run, and then shows all-zero status.
- R11: During reset the output bus is all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Receive word clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pll_lock | input | 1 | Receive PLL locked |
| test_en | input | 1 | Self-test request |
| rx_valid | input | 4 | Per-lane word strobe |
| rx_word | input | 32 | Lane k word on bits [8k+7:8k] |
| par_out | output | 32 | Forwarded data, or status fields in test mode |

## Verification
Random data with random strobes exercises the forwarding path, and shows whether each lane field follows only its own strobe. Runs of the clock symbol are sent one short of the threshold, then interrupted, then complete. These separate a detector that counts consecutive symbols from one that counts cumulatively or stops one symbol early. In the test phase, clean PRBS streams on three lanes are mixed with a heavily corrupted stream on lane 2, random strobe gaps and unlocked intervals carrying garbage words. This separates correct seeding, stepping, saturation, the pass threshold, its stickiness and lane independence from their likely failure modes. Leaving and re-entering test mode confirms that all state is cleared.

// File: rtl/mlp_pkg.sv
// Shared definitions for the multi-lane PRBS self-test checker.
// Assumes one status field per lane of ERR_W count bits plus a pass bit.
package mlp_pkg;
    parameter int ERR_W = 7;
    localparam int STAT_W = ERR_W + 1;
    localparam logic [ERR_W-1:0] ERR_MAX = '1;

    typedef struct packed {
        logic [ERR_W-1:0] err;
        logic             pass;
    } lane_stat_t;
endpackage

// File: rtl/mlp_clk_detect.sv
// Recognises entry into self-test: counts consecutive valid lane-0 words equal
// to CLK_SYM while requested and locked; raises test_active after CLK_RUN of them.
// Assumes test_active must drop whenever test_en is low.
module mlp_clk_detect #(
    parameter int WORD_W = 8,
    parameter int CLK_RUN = 128,
    parameter logic [WORD_W-1:0] CLK_SYM = 8'hF0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              test_en,
    input  logic              pll_lock,
    input  logic              valid0,
    input  logic [WORD_W-1:0] word0,
    output logic              test_active
);
    localparam int RUN_W = $clog2(CLK_RUN + 1);
    localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(CLK_RUN - 1);
    localparam logic [RUN_W-1:0] RUN_TOP = RUN_W'(CLK_RUN);

    logic [RUN_W-1:0] run_q;

    // Track the clock-symbol run and latch recognition until the request drops.
    always_ff @(posedge clk) begin
        if (!rst_n || !test_en) begin
            run_q       <= '0;
            test_active <= 1'b0;
        end else if (pll_lock && valid0) begin
            if (word0 == CLK_SYM) begin
                if (run_q == RUN_LAST) test_active <= 1'b1;
                if (run_q != RUN_TOP) run_q <= run_q + 1'b1;
            end else begin
                run_q <= '0;
            end
        end
    end
endmodule

// File: rtl/mlp_lane_check.sv
// One lane's checker: seeds a PRBS-7 state from the first accepted word,
// compares each later word with the next WORD_W generated bits, counts
// mismatches with saturation and raises a sticky pass flag after PASS_SYMS
// compared words. Assumes WORD_W >= 7 and that clearing happens while inactive.
module mlp_lane_check
    import mlp_pkg::*;
#(
    parameter int WORD_W = 8,
    parameter int PASS_SYMS = 44_000_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic              pll_lock,
    input  logic              valid,
    input  logic [WORD_W-1:0] word,
    output lane_stat_t        stat
);
    localparam int CNT_W = $clog2(PASS_SYMS + 1);
    localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(PASS_SYMS);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PASS_SYMS - 1);

    logic [6:0]       state_q;
    logic             seeded_q;
    logic [CNT_W-1:0] cnt_q;
    logic [WORD_W-1:0] expect_w;

    // Produce the next WORD_W PRBS-7 bits, first bit in the MSB.
    function automatic logic [WORD_W-1:0] prbs_word(input logic [6:0] s);
        logic [6:0]        r;
        logic              nb;
        logic [WORD_W-1:0] w;
        r = s;
        w = '0;
        for (int i = 0; i < WORD_W; i++) begin
            nb = r[6] ^ r[5];
            w[WORD_W-1-i] = nb;
            r = {r[5:0], nb};
        end
        return w;
    endfunction

    // Expected word for the current state.
    always_comb expect_w = prbs_word(state_q);

    // Seed, step, compare, count and flag on each accepted word.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            state_q   <= '0;
            seeded_q  <= 1'b0;
            cnt_q     <= '0;
            stat.err  <= '0;
            stat.pass <= 1'b0;
        end else if (pll_lock && valid) begin
            if (!seeded_q) begin
                state_q  <= word[6:0];
                seeded_q <= 1'b1;
            end else begin
                state_q <= expect_w[6:0];
                if (word != expect_w && stat.err != ERR_MAX) stat.err <= stat.err + 1'b1;
                if (cnt_q != CNT_TOP) cnt_q <= cnt_q + 1'b1;
                if (cnt_q == CNT_LAST) stat.pass <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/mlp_out_mux.sv
// Output bus: holds the last accepted word per lane and, in test mode,
// substitutes the packed per-lane status fields. Assumes WORD_W == STAT_W.
module mlp_out_mux
    import mlp_pkg::*;
#(
    parameter int NUM_LANES = 4,
    parameter int WORD_W = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          active,
    input  logic [NUM_LANES-1:0]          rx_valid,
    input  logic [NUM_LANES*WORD_W-1:0]   rx_word,
    input  lane_stat_t [NUM_LANES-1:0]    stat,
    output logic [NUM_LANES*WORD_W-1:0]   par_out
);
    logic [NUM_LANES*WORD_W-1:0] data_q;

    for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
        // Capture this lane's word whenever its strobe is high.
        always_ff @(posedge clk) begin
            if (!rst_n) data_q[l*WORD_W +: WORD_W] <= '0;
            else if (rx_valid[l]) data_q[l*WORD_W +: WORD_W] <= rx_word[l*WORD_W +: WORD_W];
        end
        // Select status or data for this lane's field.
        always_comb par_out[l*WORD_W +: WORD_W] = active ? stat[l] : data_q[l*WORD_W +: WORD_W];
    end
endmodule

// File: rtl/mlp_bist_checker.sv
// Top level of the multi-lane PRBS self-test checker: one clock-pattern
// detector on lane 0, one independent checker per lane and the output mux.
// Assumes words and status fields share the same 8-bit lane slot.
module mlp_bist_checker
    import mlp_pkg::*;
#(
    parameter int NUM_LANES = 4,
    parameter int PASS_SYMS = 44_000_000,
    parameter int CLK_RUN = 128,
    localparam int WORD_W = STAT_W,
    localparam int BUS_W = NUM_LANES * WORD_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 pll_lock,
    input  logic                 test_en,
    input  logic [NUM_LANES-1:0] rx_valid,
    input  logic [BUS_W-1:0]     rx_word,
    output logic [BUS_W-1:0]     par_out
);
    logic                        test_active;
    lane_stat_t [NUM_LANES-1:0]  lane_stat;

    mlp_clk_detect #(.WORD_W(WORD_W), .CLK_RUN(CLK_RUN), .CLK_SYM(8'hF0)) u_detect (
        .clk(clk), .rst_n(rst_n), .test_en(test_en), .pll_lock(pll_lock),
        .valid0(rx_valid[0]), .word0(rx_word[WORD_W-1:0]), .test_active(test_active)
    );

    for (genvar l = 0; l < NUM_LANES; l++) begin : g_chk
        mlp_lane_check #(.WORD_W(WORD_W), .PASS_SYMS(PASS_SYMS)) u_lane (
            .clk(clk), .rst_n(rst_n), .active(test_active), .pll_lock(pll_lock),
            .valid(rx_valid[l]), .word(rx_word[l*WORD_W +: WORD_W]), .stat(lane_stat[l])
        );
    end

    mlp_out_mux #(.NUM_LANES(NUM_LANES), .WORD_W(WORD_W)) u_mux (
        .clk(clk), .rst_n(rst_n), .active(test_active), .rx_valid(rx_valid),
        .rx_word(rx_word), .stat(lane_stat), .par_out(par_out)
    );
endmodule

// File: rtl/mlp_bist_checker_sva.sv
// Property checker for mlp_bist_checker, attached by bind below.
module mlp_bist_checker_sva
    import mlp_pkg::*;
#(
    parameter int NUM_LANES = 4
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       pll_lock,
    input logic                       active,
    input lane_stat_t [NUM_LANES-1:0] stat
);
    for (genvar l = 0; l < NUM_LANES; l++) begin : g_prop
        assert_err_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> (stat[l].err == $past(stat[l].err) ||
                      stat[l].err == $past(stat[l].err) + 1'b1 || stat[l].err == '0));
        assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (stat[l].err == ERR_MAX) |=> (stat[l].err == ERR_MAX || stat[l].err == '0));
        assert_pass_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (stat[l].pass && active) |=> stat[l].pass);
        assert_lock_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (!pll_lock && active) |=> $stable(stat[l]));
        assert_exit_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
            !active |=> (stat[l] == '0));
    end
endmodule

bind mlp_bist_checker mlp_bist_checker_sva #(.NUM_LANES(NUM_LANES)) u_sva (
    .clk(clk), .rst_n(rst_n), .pll_lock(pll_lock), .active(test_active), .stat(lane_stat)
);

// File: tb/mlp_bist_checker_bench.sv
module mlp_bist_checker_bench;
    localparam int NL = 4;
    localparam int PASS = 64;
    localparam int RUN = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pll_lock = 1'b0;
    logic          test_en = 1'b0;
    logic [NL-1:0] rx_valid = '0;
    logic [31:0]   rx_word = '0;
    logic [31:0]   par_out;

    int checks = 0;
    int errors = 0;

    // Bench model state
    bit         m_active;
    int         m_run;
    logic [7:0] m_data [NL];
    logic [6:0] m_state [NL];
    bit         m_seed [NL];
    int         m_err [NL];
    int         m_cnt [NL];
    bit         m_pass [NL];
    // Stimulus generators
    logic [6:0] tx_state [NL];
    bit         tx_seed [NL];

    mlp_bist_checker #(.NUM_LANES(NL), .PASS_SYMS(PASS), .CLK_RUN(RUN)) u_mlp_bist_checker (
        .clk(clk), .rst_n(rst_n), .pll_lock(pll_lock), .test_en(test_en),
        .rx_valid(rx_valid), .rx_word(rx_word), .par_out(par_out)
    );

    always #2 clk = ~clk;

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog: run did not finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    function automatic logic [7:0] gen8(input logic [6:0] s);
        logic [7:0] w;
        for (int i = 7; i >= 0; i--) begin
            w[i] = s[6] ^ s[5];
            s = {s[5:0], w[i]};
        end
        return w;
    endfunction

    function automatic logic [31:0] expected_bus();
        logic [31:0] b;
        for (int l = 0; l < NL; l++)
            b[l*8 +: 8] = m_active ? {7'(m_err[l]), m_pass[l]} : m_data[l];
        return b;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic model_clear();
        m_active = 0; m_run = 0;
        for (int l = 0; l < NL; l++) begin
            m_data[l] = '0; m_state[l] = '0; m_seed[l] = 0;
            m_err[l] = 0; m_cnt[l] = 0; m_pass[l] = 0; tx_seed[l] = 0;
        end
    endtask

    // Apply one cycle of stimulus, advance the model, check the bus.
    task automatic cyc(input string tag, input logic [NL-1:0] v, input logic [31:0] w);
        logic [7:0] e;
        bit old_act;
        rx_valid = v;
        rx_word = w;
        @(posedge clk);
        #1;
        old_act = m_active;
        for (int l = 0; l < NL; l++) begin
            if (v[l]) m_data[l] = w[l*8 +: 8];
            if (!old_act) begin
                m_state[l] = '0; m_seed[l] = 0; m_err[l] = 0; m_cnt[l] = 0; m_pass[l] = 0;
            end else if (pll_lock && v[l]) begin
                if (!m_seed[l]) begin
                    m_state[l] = w[l*8 +: 7]; m_seed[l] = 1;
                end else begin
                    e = gen8(m_state[l]);
                    m_state[l] = e[6:0];
                    if (w[l*8 +: 8] != e && m_err[l] < 127) m_err[l]++;
                    if (m_cnt[l] < PASS) m_cnt[l]++;
                    if (m_cnt[l] == PASS) m_pass[l] = 1;
                end
            end
        end
        if (!test_en) begin
            m_active = 0; m_run = 0;
        end else if (pll_lock && v[0]) begin
            if (w[7:0] == 8'hF0) begin
                if (m_run == RUN - 1) m_active = 1;
                if (m_run < RUN) m_run++;
            end else m_run = 0;
        end
        check(tag, par_out, expected_bus());
    endtask

    // Lane stimulus word in test mode, with optional one-bit corruption.
    function automatic logic [7:0] tx_word(input int l, input bit corrupt);
        logic [7:0] w;
        if (!tx_seed[l]) begin
            w = {1'b0, 7'($urandom_range(1, 127))};
            tx_state[l] = w[6:0];
            tx_seed[l] = 1;
        end else begin
            w = gen8(tx_state[l]);
            tx_state[l] = w[6:0];
            if (corrupt) w[$urandom_range(0, 7)] ^= 1'b1;
        end
        return w;
    endfunction

    task automatic clock_run(input string tag, input int n);
        for (int i = 0; i < n; i++) cyc(tag, 4'b0001, {24'($urandom), 8'hF0});
    endtask

    initial begin
        logic [31:0] w;
        logic [NL-1:0] v;
        logic [31:0] snap;
        bit lk;
        void'($urandom(32'd20240611));
        model_clear();
        repeat (3) @(posedge clk);
        #1;
        check("R11 reset bus", par_out, 32'h0);
        rst_n = 1'b1;

        // R1: forwarding with random strobes
        pll_lock = 1'b1;
        for (int i = 0; i < 20; i++) cyc("R1 forward", 4'($urandom), $urandom);

        // R2: short run, interruption, full run
        test_en = 1'b1;
        clock_run("R2 short run", RUN - 1);
        cyc("R2 break run", 4'b0001, 32'h0000_0033);
        clock_run("R2 full run", RUN);
        check("R3 fresh status", par_out, 32'h0);

        // R4/R5/R6/R7/R8/R9: random PRBS phase, lane 2 heavily corrupted
        for (int i = 0; i < 320; i++) begin
            lk = ($urandom_range(0, 9) != 0);
            pll_lock = lk;
            v = 4'($urandom) | 4'($urandom);
            w = $urandom;
            if (lk) begin
                for (int l = 0; l < NL; l++)
                    if (v[l]) w[l*8 +: 8] = tx_word(l, (l == 2) ? ($urandom_range(0, 9) != 0)
                                                                : ($urandom_range(0, 19) == 0));
            end
            if (m_cnt[0] == PASS - 1) check("R6 pass low before threshold", {31'h0, par_out[0]}, 32'h0);
            cyc("R4 compare stream", v, w);
        end
        pll_lock = 1'b1;
        check("R5 lane 2 saturated", {25'h0, par_out[23:17]}, 32'd127);
        check("R6 all lanes passed", {28'h0, par_out[24], par_out[16], par_out[8], par_out[0]}, 32'hF);
        check("R8 lane 1 own count", {25'h0, par_out[15:9]}, 32'(m_err[1]));

        // R7: further mismatches on every lane after pass
        for (int i = 0; i < 6; i++) cyc("R7 sticky pass", 4'hF, ~$urandom & 32'h0F0F_0F0F);
        check("R7 flags still high", {28'h0, par_out[24], par_out[16], par_out[8], par_out[0]}, 32'hF);

        // R9: unlocked garbage has no effect
        snap = par_out;
        pll_lock = 1'b0;
        for (int i = 0; i < 8; i++) cyc("R9 unlocked", 4'hF, $urandom);
        check("R9 status unchanged", par_out, snap);
        pll_lock = 1'b1;

        // R10: exit, forwarding returns, re-entry shows cleared status
        test_en = 1'b0;
        cyc("R10 exit", 4'hF, 32'hA5C3_1E77);
        check("R10 data after exit", par_out, 32'hA5C3_1E77);
        for (int l = 0; l < NL; l++) tx_seed[l] = 0;
        test_en = 1'b1;
        clock_run("R10 re-entry run", RUN);
        check("R10 status cleared", par_out, 32'h0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule